// File: doc/BRIEF.md
# Low-Power Wait and Halt Wakeup Controller

This block sits beside the CPU core of a small 8-bit microcontroller and runs its two light sleep states. A decoded wait request, or a stop request while the halt option is set, gates off the CPU bus clock. Entry also clears the interrupt mask and enables the external interrupt pin. The peripheral clocks are never touched by this block, so the timers, the serial port and the analog comparator keep running and can wake the core. If the halt option is clear, a stop request is passed on to the separate stop-mode logic through a one-cycle strobe, and this block does nothing else with it.

Any enabled wake source ends the sleep and selects a fixed 16-bit vector address. Leaving wait is immediate. Leaving halt first counts a recovery delay of 16 or 4064 bus-cycle strobes, chosen by an option bit, and only then restores the CPU clock. A watchdog timeout or a low reset pin is accepted in every state. It pulses the core reset, skips any recovery count and selects the reset vector.

The selected vector leaves on a valid/ready handshake. `vec_valid` rises when the CPU clock comes back. `vec_addr` then holds steady until the cycle in which `vec_ready` is seen high, and the CPU may hold `vec_ready` low for as long as it needs. The only exception is a new reset, which replaces a waiting vector with the reset vector. The CPU clock stays enabled while the vector waits.

Top module: `lpw_ctrl`

## Requirements
- R1: In run (`cpu_clk_en`=1, `vec_valid`=0), `wait_req` high at a clock edge gives `cpu_clk_en`=0 in the next cycle, with `imask_clr` and `irqen_set` each high for exactly that one cycle. `wait_req` wins over `stop_req` when both are high.
- R2: In wait, a wake event at a clock edge gives `cpu_clk_en`=1 and `vec_valid`=1 in the next cycle, with no recovery delay.
- R3: In run, `stop_req` with `opt_halt_en`=1 enters halt. Halt behaves as R1 (clock off, mask-clear and IRQ-enable pulses). With `opt_halt_en`=0, `stop_req` gives a one-cycle `stop_to_osc` strobe, and `cpu_clk_en` stays 1.
- R4: A wake from halt holds `cpu_clk_en`=0 until exactly N `bus_tick` strobes have been sampled after the wake edge. N is 16 when `opt_long_dly`=0 and 4064 when it is 1. The vector is offered together with the clock.
- R5: While `opt_halt_en` is 1, `stop_to_osc` never rises, so a stop request cannot switch off the watchdog.
- R6: Wake vectors: external pin or port wake 16'h1FFA, core timer 16'h1FF8, programmable timer 16'h1FF6, serial 16'h1FF4, analog comparator 16'h1FF2, reset or watchdog 16'h1FFE.
- R7: `irq_n` wakes only on a high-to-low transition. A low-to-high transition on any bit of `port_in` wakes only when `opt_port_wake`=1.
- R8: When wake sources coincide, the winner is, highest first: reset/watchdog, external pin/port, core timer, programmable timer, serial, analog.
- R9: `rst_pin_n`=0 or `wdog_tmo`=1 at any edge, in any state including halt recovery, gives `core_rst`=1, `vec_valid`=1 and `vec_addr`=16'h1FFE in the next cycle.
- R10: While `vec_valid`=1 and `vec_ready`=0, `vec_addr` stays stable. `vec_ready`=1 at an edge returns the block to run in the next cycle.
- R11: In run, wake events other than reset and watchdog are ignored: `vec_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| bus_tick | input | 1 | Free-running bus-cycle strobe |
| wait_req | input | 1 | Decoded wait request from the CPU |
| stop_req | input | 1 | Decoded stop request from the CPU |
| opt_halt_en | input | 1 | Option bit: stop requests enter halt |
| opt_long_dly | input | 1 | Option bit: 4064-cycle halt recovery instead of 16 |
| opt_port_wake | input | 1 | Option bit: port rising edges may wake |
| irq_n | input | 1 | External interrupt pin, falling edge active |
| port_in | input | NPORT | Port pins, rising edge active |
| ctmr_evt | input | 1 | Core timer overflow or periodic tick |
| ptmr_evt | input | 1 | Programmable timer capture, compare or overflow |
| ser_evt | input | 1 | Serial byte complete |
| cmp_evt | input | 1 | Analog comparison event |
| wdog_tmo | input | 1 | Watchdog timeout |
| rst_pin_n | input | 1 | External reset pin level, active low |
| vec_ready | input | 1 | CPU accepts the vector |
| cpu_clk_en | output | 1 | CPU bus clock enable |
| imask_clr | output | 1 | Pulse: clear the interrupt mask |
| irqen_set | output | 1 | Pulse: set the external IRQ enable |
| stop_to_osc | output | 1 | Pulse: stop request handed to stop-mode logic |
| core_rst | output | 1 | Core reset pulse |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | 16 | Vector address to fetch |

## Verification
On every cycle, the assertions check that entering wait turns the CPU clock off in the next cycle and gives single-cycle mask and IRQ-enable pulses. They also check that a wake from wait brings the clock and the vector back one cycle later, that the clock stays off throughout halt recovery, and that reset is taken from every state. Two more rules are checked on every cycle: the halt option always blocks the stop strobe, and the vector stays stable under back-pressure. Only the bench scenarios can show the exact recovery lengths of 16 and 4064 strobes with a steady and a sparse `bus_tick`, the per-source vector values, the ordering among coinciding sources, and the gating of port and pin edges by polarity and option.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_HALT  = 3'd2,
    ST_RECOV = 3'd3,
    ST_FETCH = 3'd4
  } lpw_state_e;

  // Vector slot k (0 = reset) sits 2*k bytes below the top vector.
  function automatic logic [15:0] slot_vec(input logic [15:0] top, input int unsigned slot);
    return top - 16'(2 * slot);
  endfunction
endpackage

// File: rtl/lpw_edge_det.sv
module lpw_edge_det #(
  parameter int W    = 1,
  parameter bit RISE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] edge_hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RISE ? '0 : '1;
    else        prev <= din;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_hit = din & ~prev;
    end else begin : g_fall
      assign edge_hit = ~din & prev;
    end
  endgenerate
endmodule

// File: rtl/lpw_wake_arb.sv
module lpw_wake_arb #(
  parameter int          NSRC    = 5,
  parameter logic [15:0] VEC_TOP = 16'h1FFE
) (
  input  logic [NSRC-1:0] req,
  output logic            hit,
  output logic [15:0]     vec
);
  // req[0] has the highest priority; slot 1 is left unused below the reset slot.
  always_comb begin
    hit = 1'b0;
    vec = VEC_TOP;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        vec = lpw_pkg::slot_vec(VEC_TOP, i + 2);
      end
    end
  end
endmodule

// File: rtl/lpw_recov_cnt.sv
module lpw_recov_cnt #(
  parameter int SHORT_DLY = 16,
  parameter int LONG_DLY  = 4064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LONG_DLY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= long_sel ? CW'(LONG_DLY) : CW'(SHORT_DLY);
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = tick && !load && (cnt == CW'(1));
endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl #(
  parameter int          NPORT     = 4,
  parameter int          SHORT_DLY = 16,
  parameter int          LONG_DLY  = 4064,
  parameter logic [15:0] VEC_TOP   = 16'h1FFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic             opt_halt_en,
  input  logic             opt_long_dly,
  input  logic             opt_port_wake,
  input  logic             irq_n,
  input  logic [NPORT-1:0] port_in,
  input  logic             ctmr_evt,
  input  logic             ptmr_evt,
  input  logic             ser_evt,
  input  logic             cmp_evt,
  input  logic             wdog_tmo,
  input  logic             rst_pin_n,
  input  logic             vec_ready,
  output logic             cpu_clk_en,
  output logic             imask_clr,
  output logic             irqen_set,
  output logic             stop_to_osc,
  output logic             core_rst,
  output logic             vec_valid,
  output logic [15:0]      vec_addr
);
  import lpw_pkg::*;
  localparam int NSRC = 5;

  lpw_state_e       state;
  logic             irq_fall;
  logic [NPORT-1:0] port_rise;
  logic             ext_wake, rst_src, wake_any, cnt_load, cnt_done;
  logic [15:0]      wake_vec;
  logic [NSRC-1:0]  src;

  lpw_edge_det #(.W(1), .RISE(1'b0)) u_irq_edge (
    .clk(clk), .rst_n(rst_n), .din(irq_n), .edge_hit(irq_fall));
  lpw_edge_det #(.W(NPORT), .RISE(1'b1)) u_port_edge (
    .clk(clk), .rst_n(rst_n), .din(port_in), .edge_hit(port_rise));

  assign ext_wake = irq_fall | (opt_port_wake & (|port_rise));
  assign rst_src  = !rst_pin_n || wdog_tmo;
  assign src      = {cmp_evt, ser_evt, ptmr_evt, ctmr_evt, ext_wake};

  lpw_wake_arb #(.NSRC(NSRC), .VEC_TOP(VEC_TOP)) u_arb (
    .req(src), .hit(wake_any), .vec(wake_vec));

  assign cnt_load = (state == ST_HALT) && wake_any && !rst_src;

  lpw_recov_cnt #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .long_sel(opt_long_dly),
    .tick(bus_tick), .done(cnt_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      vec_addr    <= VEC_TOP;
      imask_clr   <= 1'b0;
      irqen_set   <= 1'b0;
      stop_to_osc <= 1'b0;
      core_rst    <= 1'b0;
    end else begin
      imask_clr   <= 1'b0;
      irqen_set   <= 1'b0;
      stop_to_osc <= 1'b0;
      core_rst    <= 1'b0;
      if (rst_src) begin
        state    <= ST_FETCH;
        vec_addr <= VEC_TOP;
        core_rst <= 1'b1;
      end else begin
        unique case (state)
          ST_RUN: begin
            if (wait_req) begin
              state     <= ST_WAIT;
              imask_clr <= 1'b1;
              irqen_set <= 1'b1;
            end else if (stop_req) begin
              if (opt_halt_en) begin
                state     <= ST_HALT;
                imask_clr <= 1'b1;
                irqen_set <= 1'b1;
              end else begin
                stop_to_osc <= 1'b1;
              end
            end
          end
          ST_WAIT: if (wake_any) begin
            state    <= ST_FETCH;
            vec_addr <= wake_vec;
          end
          ST_HALT: if (wake_any) begin
            state    <= ST_RECOV;
            vec_addr <= wake_vec;
          end
          ST_RECOV: if (cnt_done) state <= ST_FETCH;
          ST_FETCH: if (vec_ready) state <= ST_RUN;
          default:  state <= ST_RUN;
        endcase
      end
    end
  end

  assign cpu_clk_en = (state == ST_RUN) || (state == ST_FETCH);
  assign vec_valid  = (state == ST_FETCH);
endmodule

// File: rtl/lpw_ctrl_chk.sv
module lpw_ctrl_chk #(
  parameter logic [15:0] VEC_TOP = 16'h1FFE
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wait_req,
  input logic               opt_halt_en,
  input logic               rst_pin_n,
  input logic               wdog_tmo,
  input logic               vec_ready,
  input logic               cpu_clk_en,
  input logic               imask_clr,
  input logic               irqen_set,
  input logic               stop_to_osc,
  input logic               core_rst,
  input logic               vec_valid,
  input logic [15:0]        vec_addr,
  input lpw_pkg::lpw_state_e state,
  input logic               wake_any
);
  import lpw_pkg::*;
  logic no_rst;
  assign no_rst = rst_pin_n && !wdog_tmo;

  p_wait_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !vec_valid && wait_req && no_rst) |=> (!cpu_clk_en && imask_clr && irqen_set))
    else $error("p_wait_entry_r1");

  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    imask_clr |=> !imask_clr)
    else $error("p_pulse_single_r1");

  p_wait_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && wake_any && no_rst) |=> (cpu_clk_en && vec_valid))
    else $error("p_wait_exit_r2");

  p_recov_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV) |-> !cpu_clk_en)
    else $error("p_recov_gated_r4");

  p_halt_keeps_wdog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(opt_halt_en) |-> !stop_to_osc)
    else $error("p_halt_keeps_wdog_r5");

  p_reset_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !no_rst |=> (core_rst && vec_valid && vec_addr == VEC_TOP))
    else $error("p_reset_any_r9");

  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready && no_rst) |=> (vec_valid && $stable(vec_addr)))
    else $error("p_vec_hold_r10");
endmodule

bind lpw_ctrl lpw_ctrl_chk #(.VEC_TOP(VEC_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .opt_halt_en(opt_halt_en),
  .rst_pin_n(rst_pin_n), .wdog_tmo(wdog_tmo), .vec_ready(vec_ready),
  .cpu_clk_en(cpu_clk_en), .imask_clr(imask_clr), .irqen_set(irqen_set),
  .stop_to_osc(stop_to_osc), .core_rst(core_rst), .vec_valid(vec_valid),
  .vec_addr(vec_addr), .state(state), .wake_any(wake_any));

// File: tb/lpw_ctrl_tb.sv
module lpw_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, bus_tick = 1'b1, slow_tick = 1'b0;
  logic wait_req = 0, stop_req = 0, opt_halt_en = 0, opt_long_dly = 0, opt_port_wake = 1;
  logic irq_n = 1, ctmr_evt = 0, ptmr_evt = 0, ser_evt = 0, cmp_evt = 0, wdog_tmo = 0;
  logic rst_pin_n = 1, vec_ready = 0;
  logic [3:0] port_in = '0;
  logic cpu_clk_en, imask_clr, irqen_set, stop_to_osc, core_rst, vec_valid;
  logic [15:0] vec_addr;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) bus_tick <= slow_tick ? ~bus_tick : 1'b1;

  lpw_ctrl u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_src(input int k, input bit v);
    case (k)
      0: irq_n = !v;
      1: port_in[1] = v;
      2: ctmr_evt = v;
      3: ptmr_evt = v;
      4: ser_evt = v;
      5: cmp_evt = v;
      default: wdog_tmo = v;
    endcase
  endtask

  task automatic accept(input string req);
    vec_ready = 1; @(negedge clk); vec_ready = 0;
    check(cpu_clk_en && !vec_valid, req, "back to run", {vec_valid, cpu_clk_en}, 32'h1);
  endtask

  task automatic enter_wait();
    wait_req = 1; @(negedge clk); wait_req = 0;
    check(!cpu_clk_en && imask_clr && irqen_set, "R1", "wait entry",
          {cpu_clk_en, imask_clr, irqen_set}, 32'h3);
    @(negedge clk);
    check(!imask_clr && !irqen_set && !cpu_clk_en, "R1", "pulse width",
          {cpu_clk_en, imask_clr, irqen_set}, 32'h0);
  endtask

  task automatic t_reset();
    check(cpu_clk_en && !vec_valid && !core_rst && !stop_to_osc, "R11", "reset state",
          {cpu_clk_en, vec_valid, core_rst}, 32'h4);
  endtask

  task automatic t_wait_sources();
    logic [15:0] exp [6] = '{16'h1FFA, 16'h1FFA, 16'h1FF8, 16'h1FF6, 16'h1FF4, 16'h1FF2};
    for (int k = 0; k < 6; k++) begin
      enter_wait();
      drive_src(k, 1); @(negedge clk); drive_src(k, 0);
      check(cpu_clk_en && vec_valid, "R2", "wait exit next cycle", {cpu_clk_en, vec_valid}, 32'h3);
      check(vec_addr == exp[k], "R6", "source vector", vec_addr, exp[k]);
      accept("R10");
    end
  endtask

  task automatic t_run_ignore();
    ctmr_evt = 1; ser_evt = 1; port_in[0] = 1; @(negedge clk);
    ctmr_evt = 0; ser_evt = 0; port_in[0] = 0; @(negedge clk);
    check(!vec_valid && cpu_clk_en, "R11", "events in run ignored", vec_valid, 32'h0);
  endtask

  task automatic t_stop_no_halt();
    opt_halt_en = 0; stop_req = 1; @(negedge clk); stop_req = 0;
    check(stop_to_osc && cpu_clk_en && !imask_clr, "R3", "stop passed on",
          {stop_to_osc, cpu_clk_en}, 32'h3);
    @(negedge clk);
    check(!stop_to_osc, "R3", "strobe one cycle", stop_to_osc, 32'h0);
  endtask

  task automatic t_halt(input bit long_d, input bit slow, input string req);
    int ticks = 0;
    int exp_n = long_d ? 4064 : 16;
    opt_halt_en = 1; opt_long_dly = long_d; slow_tick = slow;
    stop_req = 1; @(negedge clk); stop_req = 0;
    check(!cpu_clk_en && imask_clr && irqen_set && !stop_to_osc, "R5", "halt entry, no strobe",
          {cpu_clk_en, imask_clr, stop_to_osc}, 32'h2);
    @(negedge clk);
    ptmr_evt = 1; @(negedge clk); ptmr_evt = 0;
    while (!cpu_clk_en && ticks < 5000) begin
      if (bus_tick) ticks++;
      @(negedge clk);
    end
    check(ticks == exp_n, req, "recovery strobes", ticks, exp_n);
    check(vec_valid && vec_addr == 16'h1FF6, "R4", "vector after recovery", vec_addr, 16'h1FF6);
    accept("R10");
    slow_tick = 0; opt_long_dly = 0;
  endtask

  task automatic t_port_gate();
    irq_n = 0; @(negedge clk);
    enter_wait();
    irq_n = 1; @(negedge clk);
    check(!cpu_clk_en && !vec_valid, "R7", "irq rise no wake", vec_valid, 32'h0);
    opt_port_wake = 0; port_in[2] = 1; @(negedge clk); @(negedge clk);
    check(!cpu_clk_en && !vec_valid, "R7", "port rise gated", vec_valid, 32'h0);
    port_in[2] = 0; opt_port_wake = 1; @(negedge clk);
    port_in[3] = 1; @(negedge clk); port_in[3] = 0;
    check(vec_valid && vec_addr == 16'h1FFA, "R7", "port rise enabled", vec_addr, 16'h1FFA);
    accept("R10");
  endtask

  task automatic t_priority();
    enter_wait(); ser_evt = 1; ptmr_evt = 1; @(negedge clk); ser_evt = 0; ptmr_evt = 0;
    check(vec_addr == 16'h1FF6, "R8", "ptmr over serial", vec_addr, 16'h1FF6); accept("R10");
    enter_wait(); cmp_evt = 1; ctmr_evt = 1; @(negedge clk); cmp_evt = 0; ctmr_evt = 0;
    check(vec_addr == 16'h1FF8, "R8", "ctmr over analog", vec_addr, 16'h1FF8); accept("R10");
    enter_wait(); irq_n = 0; ctmr_evt = 1; @(negedge clk); irq_n = 1; ctmr_evt = 0;
    check(vec_addr == 16'h1FFA, "R8", "irq over ctmr", vec_addr, 16'h1FFA); accept("R10");
    enter_wait(); irq_n = 0; wdog_tmo = 1; @(negedge clk); irq_n = 1; wdog_tmo = 0;
    check(vec_addr == 16'h1FFE && core_rst, "R8", "watchdog over irq", vec_addr, 16'h1FFE);
    accept("R10");
  endtask

  task automatic t_reset_any();
    opt_halt_en = 1; opt_long_dly = 1;
    stop_req = 1; @(negedge clk); stop_req = 0;
    ser_evt = 1; @(negedge clk); ser_evt = 0;
    repeat (20) @(negedge clk);
    check(!cpu_clk_en, "R4", "still recovering", cpu_clk_en, 32'h0);
    rst_pin_n = 0; @(negedge clk); rst_pin_n = 1;
    check(core_rst && vec_valid && cpu_clk_en && vec_addr == 16'h1FFE, "R9",
          "reset skips recovery", vec_addr, 16'h1FFE);
    @(negedge clk);
    check(!core_rst && vec_valid, "R9", "core reset one cycle", core_rst, 32'h0);
    accept("R10");
    opt_long_dly = 0;
  endtask

  task automatic t_backpressure();
    enter_wait(); cmp_evt = 1; @(negedge clk); cmp_evt = 0;
    ctmr_evt = 1; repeat (5) @(negedge clk); ctmr_evt = 0;
    check(vec_valid && cpu_clk_en && vec_addr == 16'h1FF2, "R10", "vector held", vec_addr, 16'h1FF2);
    accept("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run_ignore();
    t_wait_sources();
    t_stop_no_halt();
    t_halt(1'b0, 1'b0, "R4");
    t_halt(1'b1, 1'b0, "R4");
    t_halt(1'b0, 1'b1, "R4");
    t_port_gate();
    t_priority();
    t_reset_any();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule